// File: doc/BRIEF.md
# Watchdog Reset Pin Controller with Strap-Selected Role

This block owns one bidirectional board pin whose role is decided once, when the chip comes out of power-up reset, from a mode strap. With the strap high (the default, because of its pull-up) the pin is an active-low power-down request input. The block synchronises the pin level and presents a registered, active-high power-down request to the rest of the chip. With the strap low the pin becomes an open-drain, active-low reset output driven by a watchdog.

In the reset-output role, a counter clocked by the 14.318 MHz reference measures the time since the last kick. Firmware or a supervising block restarts the count by pulsing the kick input. If the count expires, the block pulls the pin low for a fixed pulse length, 4 ms or 57,272 reference cycles by default. It then releases the pin and starts counting again. The pin is only ever pulled low: the block drives an output-enable whose driven value is always 0, and a pull-up takes the pin high when it is released.

Top module: `wdr_pin_ctrl`

## Requirements
- R1: While `rst` is high the strap level is captured on every clock, and the value held at the last reset cycle fixes the role until the next reset: 1 selects the power-down input role, 0 selects the reset output role. Strap changes after reset have no effect on either output.
- R2: While `rst` is high, `pin_oe_o` and `pwrdn_req_o` are both 0 after each clock edge.
- R3: In the power-down role, `pwrdn_req_o` equals the inverse of `pin_i`, delayed by two synchroniser stages and one output register. A level sampled at clock edge k appears on the output after edge k+2.
- R4: In the power-down role, `pin_oe_o` is never asserted and `kick_i` has no effect. The watchdog is held cleared.
- R5: In the reset role, `pwrdn_req_o` stays 0 whatever the pin level, including when the pin is held low externally.
- R6: In the reset role, if no kick arrives, `pin_oe_o` rises after the TIMEOUT_CYCLES-th clock edge that follows reset release, the end of a pulse, or a kick.
- R7: A kick in the reset role outside a pulse restarts the count. A clock edge that samples a kick never starts a pulse.
- R8: Once asserted, `pin_oe_o` stays high for exactly PULSE_CYCLES clock cycles (57,272 by default, 4 ms of the reference clock) and then releases.
- R9: Kicks that arrive while the pulse is active are ignored. They neither shorten nor extend the pulse, and the next timeout is still counted from the end of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (14.318 MHz) |
| rst | input | 1 | Synchronous active-high power-up reset; the strap is captured while it is high |
| strap_i | input | 1 | Mode strap level (1 = power-down input role, 0 = reset output role) |
| pin_i | input | 1 | Level read back from the shared pin |
| kick_i | input | 1 | Watchdog restart pulse |
| pin_oe_o | output | 1 | Pull-down enable for the pin (pin driven to 0 when high) |
| pwrdn_req_o | output | 1 | Registered active-high power-down request |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 12 and PULSE_CYCLES = 5. At these values several complete timeout and pulse periods fit into a few hundred clocks. Kicks can be placed on the exact expiry edge and on the first and last cycles of a pulse. The bench also flips the strap after reset in both roles. The default 57,272-cycle pulse is covered by the same counter logic but is not exercised at its full length.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef enum logic {
    ROLE_RESET_OUT = 1'b0,
    ROLE_PWRDN_IN  = 1'b1
  } pin_role_e;
endpackage

// File: rtl/wdr_strap_latch.sv
module wdr_strap_latch
  import wdr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      strap_i,
  output pin_role_e role_o
);
  pin_role_e role_q;

  // Strap is followed only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) role_q <= pin_role_e'(strap_i);
  end

  assign role_o = role_q;

  // R1: role never changes outside reset
  a_r1_role_frozen: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(role_q));
endmodule

// File: rtl/wdr_sync.sv
module wdr_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RST_VAL;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= RST_VAL;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdr_watchdog.sv
module wdr_watchdog #(
  parameter int TIMEOUT_CYCLES = 7_159_000,
  parameter int PULSE_CYCLES   = 57_272
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic kick_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int PLS_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [PLS_W-1:0] PLS_LAST = PLS_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PLS_W-1:0] pcnt_q;
  logic             pulse_q;

  always_ff @(posedge clk) begin
    if (rst || !enable_i) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      if (pcnt_q == PLS_LAST) begin
        pulse_q <= 1'b0;
        pcnt_q  <= '0;
      end else begin
        pcnt_q  <= pcnt_q + 1'b1;
      end
    end else if (kick_i) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      pulse_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = pulse_q;

  // R7: a sampled kick outside a pulse never starts one
  a_r7_kick_blocks: assert property (@(posedge clk) disable iff (rst)
    (enable_i && kick_i && !pulse_q) |=> !pulse_q);
  // R8: pulse only ends after its full length
  a_r8_pulse_len: assert property (@(posedge clk) disable iff (rst)
    (enable_i && $fell(pulse_q)) |-> ($past(pcnt_q) == PLS_LAST));
  // R4: disabled watchdog never pulses
  a_r4_held_clear: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> !pulse_q);
endmodule

// File: rtl/wdr_pin_ctrl.sv
module wdr_pin_ctrl
  import wdr_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 7_159_000,
  parameter int PULSE_CYCLES   = 57_272,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strap_i,
  input  logic pin_i,
  input  logic kick_i,
  output logic pin_oe_o,
  output logic pwrdn_req_o
);
  pin_role_e role;
  logic      pin_sync;
  logic      wd_pulse;
  logic      req_q;

  wdr_strap_latch u_strap (
    .clk    (clk),
    .rst    (rst),
    .strap_i(strap_i),
    .role_o (role)
  );

  wdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(pin_i),
    .q_o(pin_sync)
  );

  wdr_watchdog #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .PULSE_CYCLES  (PULSE_CYCLES)
  ) u_wd (
    .clk     (clk),
    .rst     (rst),
    .enable_i(role == ROLE_RESET_OUT),
    .kick_i  (kick_i),
    .pulse_o (wd_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= (role == ROLE_PWRDN_IN) && !pin_sync;
  end

  assign pwrdn_req_o = req_q;
  assign pin_oe_o    = wd_pulse;

  // R4: no pull-down in power-down role
  a_r4_no_drive_pd: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_PWRDN_IN) |-> !pin_oe_o);
  // R5: no power-down request in reset role
  a_r5_no_req_rst: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_RESET_OUT) |-> !pwrdn_req_o);
  // R2: outputs cleared by reset
  a_r2_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!pin_oe_o && !pwrdn_req_o));
endmodule

// File: tb/wdr_pin_ctrl_tb_top.sv
module wdr_pin_ctrl_tb_top;
  localparam int T = 12;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b0;
  logic kick = 1'b0;
  logic ext_low = 1'b0;
  logic pin_oe, pwrdn_req, pin;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign pin = ~(ext_low | pin_oe);

  wdr_pin_ctrl #(.TIMEOUT_CYCLES(T), .PULSE_CYCLES(P)) dut_i (
    .clk(clk), .rst(rst), .strap_i(strap), .pin_i(pin),
    .kick_i(kick), .pin_oe_o(pin_oe), .pwrdn_req_o(pwrdn_req)
  );

  // Behavioural reference: edges since restart, pulse age, delay line.
  bit m_pd, m_oe, m_req;
  int m_wait, m_age;
  bit m_dly[$];

  always @(posedge clk) begin
    bit pin_now;
    pin_now = ~(ext_low | m_oe);
    if (rst) begin
      m_pd = strap; m_oe = 0; m_req = 0; m_wait = 0; m_age = 0;
      m_dly = '{1'b1, 1'b1};
    end else begin
      m_req = m_pd && !m_dly[0];
      void'(m_dly.pop_front());
      m_dly.push_back(pin_now);
      if (m_pd) begin
        m_oe = 0; m_wait = 0;
      end else if (m_oe) begin
        if (m_age == P) begin m_oe = 0; m_wait = 0; end
        else m_age++;
      end else if (kick) begin
        m_wait = 0;
      end else begin
        m_wait++;
        if (m_wait == T) begin m_oe = 1; m_age = 1; m_wait = 0; end
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle compare at negedge, away from the active edge.
  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst) begin
        check("R2 pin_oe in reset", pin_oe, 1'b0);
        check("R2 pwrdn_req in reset", pwrdn_req, 1'b0);
      end else if (m_pd) begin
        check("R4 pin_oe pd role", pin_oe, m_oe);
        check("R3 pwrdn_req pd role", pwrdn_req, m_req);
      end else begin
        check("R6 R7 R8 R9 pin_oe reset role", pin_oe, m_oe);
        check("R5 pwrdn_req reset role", pwrdn_req, m_req);
      end
    end
  endtask

  task automatic do_reset(logic s);
    rst = 1'b1; strap = s; kick = 1'b0; ext_low = 1'b0;
    cyc(3);
    rst = 1'b0;
  endtask

  int edges;

  initial begin
    // Reset role, free-running timeout.
    do_reset(1'b0);
    cyc(T - 1);
    check("R6 no pulse before timeout", pin_oe, 1'b0);
    cyc(1);
    check("R6 pulse at timeout", pin_oe, 1'b1);
    cyc(P - 1);
    check("R8 pulse still high", pin_oe, 1'b1);
    cyc(1);
    check("R8 pulse released", pin_oe, 1'b0);
    cyc(T - 1);
    check("R6 count restarts after pulse", pin_oe, 1'b0);
    cyc(1);
    check("R6 second pulse", pin_oe, 1'b1);
    // R9: kicks during the pulse are ignored
    kick = 1'b1; cyc(P - 1); kick = 1'b0;
    check("R9 pulse not shortened", pin_oe, 1'b1);
    cyc(1);
    check("R9 pulse not extended", pin_oe, 1'b0);
    // R7: kick on the expiry edge
    cyc(T - 1);
    kick = 1'b1; cyc(1); kick = 1'b0;
    check("R7 kick at expiry blocks pulse", pin_oe, 1'b0);
    // R7: periodic kicks keep pin released
    edges = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(T - 2);
      edges += pin_oe;
      kick = 1'b1; cyc(1); kick = 1'b0;
    end
    check("R7 periodic kick no pulse", edges != 0, 1'b0);
    // R5: external low on pin, R1: strap flips after reset
    ext_low = 1'b1; strap = 1'b1;
    cyc(4);
    check("R5 no request on low pin", pwrdn_req, 1'b0);
    ext_low = 1'b0;
    cyc(3 * (T + P));
    check("R1 strap change ignored in reset role", pwrdn_req, 1'b0);

    // Power-down role.
    do_reset(1'b1);
    cyc(2);
    check("R3 idle request low", pwrdn_req, 1'b0);
    ext_low = 1'b1;
    cyc(2);
    check("R3 request not yet visible", pwrdn_req, 1'b0);
    cyc(1);
    check("R3 request after sync", pwrdn_req, 1'b1);
    ext_low = 1'b0;
    cyc(3);
    check("R3 request clears", pwrdn_req, 1'b0);
    ext_low = 1'b1; cyc(1); ext_low = 1'b0;
    cyc(2);
    check("R3 single-cycle low passes", pwrdn_req, 1'b1);
    cyc(1);
    check("R3 single-cycle low ends", pwrdn_req, 1'b0);
    // R4: no pulses and kicks do nothing; R1: strap flip ignored
    strap = 1'b0;
    kick = 1'b1; cyc(T + 2); kick = 1'b0;
    cyc(3 * (T + P));
    check("R4 no pull-down in pd role", pin_oe, 1'b0);
    ext_low = 1'b1; cyc(3);
    check("R1 pd role kept after strap flip", pwrdn_req, 1'b1);
    ext_low = 1'b0; cyc(3);

    // R1: back to reset role via a new reset.
    do_reset(1'b0);
    cyc(T);
    check("R1 new reset selects reset role", pin_oe, 1'b1);
    cyc(P + 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule